// File: doc/BRIEF.md
# BiSS-C Position Frame Master

This block is the master end of a one-way BiSS-C link to an absolute position encoder. When software logic pulses a request, the block starts toggling the MA line at a rate set by a runtime half-period divider. It then follows the slave's reply on SLO. First it waits for the acknowledge low, then for the start bit (always 1) and the fixed 0 bit. After those it shifts in the position word, the active-low error and warning flags and the 6-bit CRC. When the last bit is in, MA stops high, the captured fields appear on parallel outputs and a one-cycle valid strobe fires.

The encoder reply returns through line drivers and cable, so it lags MA. SLO is therefore read a fixed number of system clocks after each MA rising edge, and that number is a parameter. The CRC arithmetic lives in a separate checker. That checker reads the held position and flag outputs and returns its expected CRC, and the block compares it with the inverted CRC it received. A reply that never starts, or a start bit not followed by the 0 bit, aborts the cycle and sets an error flag. Between cycles the block keeps to the slave's busy-low period and to a minimum spacing between request starts.

Top module: `biss_master`

## Requirements
- R1: After reset MA is high, busy is low, data_valid is low and resp_err is low. MA stays high whenever busy is low.
- R2: A request pulse is accepted only while the block is idle, SLO is high and the spacing interval has elapsed. Otherwise it is ignored: busy stays low and MA stays high.
- R3: Once a request is accepted, the first MA falling edge comes exactly half_div system clocks after busy rises. Successive MA falling edges are exactly 2*half_div clocks apart.
- R4: Acknowledge lows of any length are accepted. The data that follows the start bit is decoded the same way whatever the acknowledge length.
- R5: The sample after the start bit must be 0. If it reads 1, the cycle is aborted with resp_err=1 and no data_valid.
- R6: After the 0 bit the block receives POS_W position bits MSB first, then n_error, then n_warning, then the 6 CRC bits MSB first. These appear on position, n_error and n_warning.
- R7: crc_ok is 1 exactly when the bitwise inverse of the received CRC field equals crc_ref.
- R8: data_valid is a single-cycle pulse issued once per good frame. MA is high at that pulse and stays high afterwards.
- R9: If the start bit has not been sampled by the ack_limit-th MA rising edge of a cycle, the block stops MA high, sets resp_err and issues no data_valid. A start bit on exactly that edge is still accepted.
- R10: After a frame or an abort, busy stays high while SLO is low. Busy falls within a few clocks after SLO returns high, once at least one MA period has passed since the stop.
- R11: Two accepted requests are never closer than SPACING_CYC system clocks.
- R12: SLO is sampled LINE_DLY system clocks after each MA rising edge. A slave whose output settles less than LINE_DLY clocks after the edge is read correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request pulse to start an acquisition cycle |
| half_div | input | DIV_W | MA half period in system clocks (greater than LINE_DLY) |
| ack_limit | input | LIM_W | Last MA rising edge on which the start bit may arrive |
| slo | input | 1 | Serial data from the encoder |
| crc_ref | input | 6 | Expected CRC from the external checker for the held outputs |
| ma | output | 1 | Clock to the encoder, high when idle |
| busy | output | 1 | High from acceptance until the slave releases SLO |
| data_valid | output | 1 | One-cycle strobe for a completed frame |
| position | output | POS_W | Received position word |
| n_error | output | 1 | Received error flag, active low |
| n_warning | output | 1 | Received warning flag, active low |
| crc_ok | output | 1 | Received CRC matches crc_ref |
| resp_err | output | 1 | Last cycle aborted for a missing or malformed reply |

## Verification
Random frames vary the position word, both flags, the acknowledge length, the divider and the busy-low period. This shows that decoding does not depend on where the start bit falls and that MA timing follows the divider. Frames with one CRC bit flipped separate a real CRC comparison from a constant. A silent slave, a bad 0 bit, and acknowledge lengths on either side of ack_limit separate the abort paths from normal reception. Requests made too early and requests made while SLO is low must leave MA untouched. The slave's reply settles just before the delayed sample point, so a shorter compensation delay would read stale bits.

// File: rtl/biss_pkg.sv
// Package: shared constants and the sequencer state type for the BiSS-C master.
package biss_pkg;
    localparam int CRC_W = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_START,
        ST_ZERO,
        ST_DATA,
        ST_TMO
    } link_state_t;
endpackage

// File: rtl/biss_ma_gen.sv
// MA clock generator.
// Holds MA high while run is low. While run is high it toggles MA every
// half_div system clocks, starting with a falling edge. It also gives a
// one-cycle pulse on the cycle where MA has just gone high.
// Assumes half_div >= 2.
module biss_ma_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             ma,
    output logic             rise
);
    logic [DIV_W-1:0] ph_cnt;

    // Phase counter and MA toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ma     <= 1'b1;
            ph_cnt <= '0;
            rise   <= 1'b0;
        end else begin
            rise <= 1'b0;
            if (!run) begin
                ma     <= 1'b1;
                ph_cnt <= '0;
            end else if (ph_cnt >= half_div - 1'b1) begin
                ph_cnt <= '0;
                ma     <= ~ma;
                rise   <= ~ma;
            end else begin
                ph_cnt <= ph_cnt + 1'b1;
            end
        end
    end

    // R3: a rising edge only ever follows a full phase while running.
    a_r3_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(run));
endmodule

// File: rtl/biss_tick_delay.sv
// Line-delay compensation.
// Delays the MA rise pulse so that SLO is sampled DLY system clocks after
// the MA edge. The pulse is already one clock late, so DLY-1 further stages
// are added.
// Assumes DLY >= 1.
module biss_tick_delay #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic tick_out
);
    generate
        if (DLY <= 1) begin : g_direct
            assign tick_out = tick_in;
        end else begin : g_pipe
            logic [DLY-2:0] pipe;
            // Shift the pulse through DLY-1 register stages.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe <= '0;
                end else begin
                    pipe[0] <= tick_in;
                    for (int k = 1; k <= DLY - 2; k++) begin
                        pipe[k] <= pipe[k-1];
                    end
                end
            end
            assign tick_out = pipe[DLY-2];
        end
    endgenerate
endmodule

// File: rtl/biss_shift_in.sv
// Serial-in frame register.
// Shifts din in MSB first on each enable. It flags the enable that delivers
// the W-th bit and presents the completed word combinationally on that cycle.
// clr restarts the count.
module biss_shift_in #(
    parameter int W = 34
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] word_nxt,
    output logic         last
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     q;
    logic [CNT_W-1:0] cnt;

    assign word_nxt = {q[W-2:0], din};
    assign last     = en && (cnt == CNT_W'(W - 1));

    // Shift register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= '0;
            cnt <= '0;
        end else if (clr) begin
            q   <= '0;
            cnt <= '0;
        end else if (en) begin
            q   <= word_nxt;
            cnt <= cnt + 1'b1;
        end
    end

    // R6: the counter never runs past the frame length.
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(W));
endmodule

// File: rtl/biss_master.sv
// BiSS-C master acquisition sequencer (top).
// It accepts a request, runs MA and follows the slave through acknowledge,
// start bit, 0 bit and data. It then captures the fields and waits out the
// slave's busy-low time and the request spacing.
// Assumes half_div > LINE_DLY, so each delayed sample lands while MA is still
// high, and ack_limit >= 2.
module biss_master #(
    parameter int POS_W       = 26,
    parameter int DIV_W       = 16,
    parameter int LIM_W       = 8,
    parameter int LINE_DLY    = 2,
    parameter int SPACING_CYC = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [DIV_W-1:0] half_div,
    input  logic [LIM_W-1:0] ack_limit,
    input  logic             slo,
    input  logic [5:0]       crc_ref,
    output logic             ma,
    output logic             busy,
    output logic             data_valid,
    output logic [POS_W-1:0] position,
    output logic             n_error,
    output logic             n_warning,
    output logic             crc_ok,
    output logic             resp_err
);
    import biss_pkg::*;

    localparam int FRAME_W = POS_W + 2 + CRC_W;
    localparam int SPC_W   = $clog2(SPACING_CYC + 1);
    localparam int GRD_W   = DIV_W + 1;

    link_state_t         state;
    logic                run;
    logic                rise;
    logic                samp;
    logic [LIM_W-1:0]    edge_cnt;
    logic [LIM_W:0]      edge_nxt;
    logic                lim_hit;
    logic [GRD_W-1:0]    grd_cnt;
    logic                grd_done;
    logic [SPC_W-1:0]    spc_cnt;
    logic                accept;
    logic                shift_en;
    logic [FRAME_W-1:0]  word_nxt;
    logic                word_last;
    logic [CRC_W-1:0]    rx_crc;

    biss_ma_gen #(.DIV_W(DIV_W)) u_ma (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_div (half_div),
        .ma       (ma),
        .rise     (rise)
    );

    biss_tick_delay #(.DLY(LINE_DLY)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (rise),
        .tick_out (samp)
    );

    biss_shift_in #(.W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .en       (shift_en),
        .din      (slo),
        .word_nxt (word_nxt),
        .last     (word_last)
    );

    assign busy     = (state != ST_IDLE);
    assign accept   = (state == ST_IDLE) && req && slo && (spc_cnt == '0);
    assign shift_en = samp && (state == ST_DATA);
    assign edge_nxt = {1'b0, edge_cnt} + 1'b1;
    assign lim_hit  = edge_nxt >= {1'b0, ack_limit};
    assign grd_done = grd_cnt >= {half_div, 1'b0};
    assign crc_ok   = (~rx_crc) == crc_ref;

    // Request spacing: counts down from each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spc_cnt <= '0;
        end else if (accept) begin
            spc_cnt <= SPC_W'(SPACING_CYC - 1);
        end else if (spc_cnt != '0) begin
            spc_cnt <= spc_cnt - 1'b1;
        end
    end

    // Sequencer: walks the reply phases, captures fields, handles aborts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            run        <= 1'b0;
            edge_cnt   <= '0;
            grd_cnt    <= '0;
            data_valid <= 1'b0;
            resp_err   <= 1'b0;
            position   <= '0;
            n_error    <= 1'b1;
            n_warning  <= 1'b1;
            rx_crc     <= '0;
        end else begin
            data_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_ACK;
                        run      <= 1'b1;
                        edge_cnt <= '0;
                        resp_err <= 1'b0;
                    end
                end
                ST_ACK: begin
                    if (samp) begin
                        edge_cnt <= edge_nxt[LIM_W-1:0];
                        if (lim_hit) begin
                            state    <= ST_TMO;
                            run      <= 1'b0;
                            resp_err <= 1'b1;
                            grd_cnt  <= '0;
                        end else if (!slo) begin
                            state <= ST_START;
                        end
                    end
                end
                ST_START: begin
                    if (samp) begin
                        edge_cnt <= edge_nxt[LIM_W-1:0];
                        if (slo) begin
                            state <= ST_ZERO;
                        end else if (lim_hit) begin
                            state    <= ST_TMO;
                            run      <= 1'b0;
                            resp_err <= 1'b1;
                            grd_cnt  <= '0;
                        end
                    end
                end
                ST_ZERO: begin
                    if (samp) begin
                        if (!slo) begin
                            state <= ST_DATA;
                        end else begin
                            state    <= ST_TMO;
                            run      <= 1'b0;
                            resp_err <= 1'b1;
                            grd_cnt  <= '0;
                        end
                    end
                end
                ST_DATA: begin
                    if (word_last) begin
                        state      <= ST_TMO;
                        run        <= 1'b0;
                        data_valid <= 1'b1;
                        grd_cnt    <= '0;
                        position   <= word_nxt[FRAME_W-1 -: POS_W];
                        n_error    <= word_nxt[CRC_W+1];
                        n_warning  <= word_nxt[CRC_W];
                        rx_crc     <= word_nxt[CRC_W-1:0];
                    end
                end
                ST_TMO: begin
                    if (!grd_done) begin
                        grd_cnt <= grd_cnt + 1'b1;
                    end else if (slo) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: MA rests high whenever no cycle is in progress.
    a_r1_idle_ma_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ma);
    // R2: a cycle only starts while the slave signals ready.
    a_r2_start_needs_slo: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(slo));
    // R8: the valid strobe lasts one cycle and finds MA high.
    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);
    a_r8_valid_ma_high: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> ma);
    // R9: an abort never comes with a valid strobe.
    a_r9_abort_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_err) |-> !data_valid);
    // R10: busy ends only after the slave released SLO.
    a_r10_busy_end_slo: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(slo));
    // R11: a new cycle starts only with the spacing counter drained.
    a_r11_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(spc_cnt == '0));
endmodule

// File: tb/biss_master_test.sv
`timescale 1ns/1ps
module biss_master_test;
    localparam int POS_W   = 26;
    localparam int DIV_W   = 16;
    localparam int LIM_W   = 8;
    localparam int DLY     = 3;
    localparam int SPC     = 800;
    localparam int FRAME_W = POS_W + 8;
    localparam int LAG_NS  = (DLY - 1) * 8 + 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req = 1'b0;
    logic [DIV_W-1:0] half_div = 16'd4;
    logic [LIM_W-1:0] ack_limit = 8'd20;
    logic             slo = 1'b1;
    logic [5:0]       crc_ref;
    logic             ma, busy, data_valid, n_error, n_warning, crc_ok, resp_err;
    logic [POS_W-1:0] position;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #4 clk = ~clk;

    biss_master #(
        .POS_W(POS_W), .DIV_W(DIV_W), .LIM_W(LIM_W),
        .LINE_DLY(DLY), .SPACING_CYC(SPC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .half_div(half_div),
        .ack_limit(ack_limit), .slo(slo), .crc_ref(crc_ref), .ma(ma),
        .busy(busy), .data_valid(data_valid), .position(position),
        .n_error(n_error), .n_warning(n_warning), .crc_ok(crc_ok),
        .resp_err(resp_err)
    );

    // CRC x^6 + x + 1, zero start, MSB first.
    function automatic logic [5:0] crc6(input logic [POS_W+1:0] d);
        logic [5:0] c = '0;
        for (int i = POS_W + 1; i >= 0; i--) begin
            logic fb = c[5] ^ d[i];
            c = {c[4:0], 1'b0};
            if (fb) c = c ^ 6'h03;
        end
        return c;
    endfunction

    // Bench stand-in for the external CRC checker.
    always_comb crc_ref = crc6({position, n_error, n_warning});

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Monitors sampled on the falling clock edge.
    int v_cnt = 0;
    logic [POS_W-1:0] cap_pos;
    logic cap_ne, cap_nw, cap_ok, cap_ma;
    logic ma_q = 1'b1, busy_q = 1'b0;
    int t_acc = 0, t_fall = 0, prev_acc = -100000;
    bit fall_seen = 0;
    always @(negedge clk) begin
        cyc++;
        if (data_valid) begin
            v_cnt++;
            cap_pos = position; cap_ne = n_error; cap_nw = n_warning;
            cap_ok = crc_ok; cap_ma = ma;
        end
        if (busy && !busy_q) begin
            check("R11 spacing", 64'(cyc - prev_acc >= SPC), 64'd1);
            prev_acc = cyc; t_acc = cyc; fall_seen = 0;
        end
        if (!ma && ma_q) begin
            if (fall_seen) check("R3 period", 64'(cyc - t_fall), 64'(2 * half_div));
            else           check("R3 first fall", 64'(cyc - t_acc), 64'(half_div));
            fall_seen = 1; t_fall = cyc;
        end
        ma_q = ma; busy_q = busy;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic wait_ready();
        while (busy) @(negedge clk);
        while (cyc - prev_acc < SPC + 2) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
    endtask

    task automatic slave_edge(input logic v);
        @(posedge ma); #(LAG_NS); slo = v;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 400) begin @(negedge clk); n++; end
    endtask

    // mode 0: good frame, 1: silent, 2: bad 0 bit, 3: start too late
    task automatic frame(input logic [POS_W-1:0] pos, input logic ne, input logic nw,
                         input int ack_len, input bit crc_bad, input int tmo, input int mode);
        logic [5:0] c;
        logic [FRAME_W-1:0] bits;
        c = ~crc6({pos, ne, nw});
        if (crc_bad) c[0] = ~c[0];
        bits = {pos, ne, nw, c};
        wait_ready();
        v_cnt = 0;
        pulse_req();
        check("R2 accept", 64'(busy), 64'd1);
        if (mode == 1) begin
            wait_idle();
        end else if (mode == 3) begin
            slave_edge(1'b1);
            for (int i = 0; i < ack_len; i++) slave_edge(1'b0);
            repeat (2) @(negedge clk);
            slo = 1'b1;
            wait_idle();
        end else begin
            slave_edge(1'b1);
            for (int i = 0; i < ack_len; i++) slave_edge(1'b0);
            slave_edge(1'b1);
            slave_edge(mode == 2);
            if (mode == 2) begin
                repeat (2) @(negedge clk);
                slo = 1'b1;
                wait_idle();
            end else begin
                for (int i = FRAME_W - 1; i >= 0; i--) slave_edge(bits[i]);
                #16 slo = (tmo == 0);
                repeat (tmo) @(negedge clk);
                if (tmo > 12) check("R10 busy held while SLO low", 64'(busy), 64'd1);
                slo = 1'b1;
                wait_idle();
            end
        end
        check("R10 busy released", 64'(busy), 64'd0);
        check("R8 MA high after cycle", 64'(ma), 64'd1);
        if (mode == 0) begin
            check("R8 one valid", 64'(v_cnt), 64'd1);
            check("R6 position", 64'(cap_pos), 64'(pos));
            check("R6 flags", 64'({cap_ne, cap_nw}), 64'({ne, nw}));
            check("R7 crc_ok", 64'(cap_ok), 64'(!crc_bad));
            check("R8 MA high at valid", 64'(cap_ma), 64'd1);
            check("R9 no resp_err", 64'(resp_err), 64'd0);
        end else begin
            check("R9/R5 no valid on abort", 64'(v_cnt), 64'd0);
            check("R9/R5 resp_err", 64'(resp_err), 64'd1);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ma", 64'(ma), 64'd1);
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 valid", 64'(data_valid), 64'd0);
        check("R1 resp_err", 64'(resp_err), 64'd0);

        // R4 R6 R7 R12: random frames, varied ack, divider and timeout.
        for (int f = 0; f < 16; f++) begin
            half_div = 16'($urandom_range(4, 7));
            frame(POS_W'($urandom), 1'($urandom), 1'($urandom),
                  int'($urandom_range(1, 5)), ($urandom_range(0, 5) == 0),
                  int'($urandom_range(0, 30)), 0);
        end
        // Directed field extremes.
        half_div = 16'd4;
        frame('1, 1'b0, 1'b0, 1, 1'b0, 20, 0);
        frame('0, 1'b1, 1'b1, 3, 1'b1, 0, 0);

        // R2 R11: early request after a cycle is ignored.
        while (busy) @(negedge clk);
        pulse_req();
        repeat (3) @(negedge clk);
        check("R2 early request ignored busy", 64'(busy), 64'd0);
        check("R11 early request ignored ma", 64'(ma), 64'd1);
        // R2: request while SLO low is ignored.
        wait_ready();
        slo = 1'b0;
        pulse_req();
        repeat (3) @(negedge clk);
        check("R2 SLO-low request ignored busy", 64'(busy), 64'd0);
        check("R2 SLO-low request ignored ma", 64'(ma), 64'd1);
        slo = 1'b1;

        // R9: silent slave, and start on either side of the limit edge.
        ack_limit = 8'd10;
        frame('0, 1'b1, 1'b1, 0, 1'b0, 0, 1);
        frame(POS_W'(26'h2AAAAAA), 1'b1, 1'b0, 8, 1'b0, 5, 0);
        frame('0, 1'b1, 1'b1, 9, 1'b0, 0, 3);
        ack_limit = 8'd20;
        // R5: 0 bit read as 1.
        frame('0, 1'b1, 1'b1, 2, 1'b0, 0, 2);
        // Recovery after aborts.
        frame(POS_W'(26'h1234567), 1'b0, 1'b1, 2, 1'b0, 15, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule